// File: doc/BRIEF.md
# Operand Address Sequencer

This block works out where an instruction operand lives for a 16-bit processor with eight registers and eight general addressing modes. A caller hands it a 3-bit mode, a 3-bit register index, a byte/word flag and a flag that says whether the operand value is wanted. The sequencer then steps through the register reads, the register updates (post-increment, pre-decrement, program-counter advance) and the memory reads that the mode needs. It finishes with a one-cycle done pulse. At that point it presents the effective address, the operand value and a flag that says whether the operand is a register rather than a memory location.

The register file sits outside the block. Its read port is combinational and is steered by `rf_rd_idx`; its write port is taken on the clock edge. Memory is reached through a request/acknowledge port. A request is held until the cycle in which the acknowledge arrives, and read data is valid in that cycle. Each request carries a space tag, instruction or data, and a byte flag.

Top module: `amseq_top`

## Requirements
- R1: While reset is asserted and right after it is released, `idle` is 1, and `done`, `mem_req` and `rf_wr_en` are 0.
- R2: Mode 0 returns the register value as the operand, with `is_reg`=1 and `ea`=0. In byte mode (`req_byte`=1) only the low 8 bits are kept. No memory request and no register write take place.
- R3: Mode 1 uses the register value as `ea`, and the register is left unchanged.
- R4: Mode 2 uses the register value as `ea` and then adds a step to the register. The step is 1 when `req_byte`=1 and the register index is 0..5. It is 2 otherwise, which includes index 6 and index 7 (the PC).
- R5: Mode 3 reads a word at the register value, returns that word as `ea`, and adds 2 to the register whatever the byte flag says.
- R6: Mode 4 first subtracts the R4 step from the register, modulo 2^16, and then uses the new value as `ea`.
- R7: Mode 5 subtracts 2 from the register, reads a word at the new value, and returns that word as `ea`.
- R8: Mode 6 reads a word at the PC (register 7) from instruction space and adds 2 to the PC. `ea` is the index word plus the register; when the register is 7, the advanced PC value is used.
- R9: Mode 7 forms the same sum as mode 6 and then reads a word at that sum from data space. That word is `ea`.
- R10: Space tag (`mem_dspace`, 1 = data). Operand reads in modes 1, 2 and 4, and pointer reads in modes 3 and 5, use instruction space when the register is 7 and data space otherwise. All operand reads in modes 3, 5, 6 and 7 use data space.
- R11: With `req_read`=0 the block issues no operand read, and `operand` is 0 at done. Any pointer or index reads still take place.
- R12: `done` is high for exactly one cycle. A request presented while `idle` is 0 is ignored, and it causes neither a second done nor any change to the result.
- R13: In byte mode the operand read is issued with `mem_byte`=1 and `operand` holds only the low 8 bits of the read data. Pointer and index reads are always words (`mem_byte`=0).
- R14: A memory request keeps `mem_req`, `mem_addr` and `mem_dspace` unchanged until the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request; taken only while idle |
| req_mode | input | 3 | Addressing mode 0..7 |
| req_reg | input | 3 | Register index 0..7 (7 = PC, 6 = stack pointer) |
| req_byte | input | 1 | 1 = byte operand |
| req_read | input | 1 | 1 = fetch the operand value |
| idle | output | 1 | Ready to take a request |
| done | output | 1 | One-cycle completion pulse |
| ea | output | DW | Effective address (0 in mode 0) |
| operand | output | DW | Operand value |
| is_reg | output | 1 | Operand is the register itself |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | DW | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | DW | Register file write data |
| mem_req | output | 1 | Memory read request, held until ack |
| mem_addr | output | DW | Memory read address |
| mem_dspace | output | 1 | 1 = data space, 0 = instruction space |
| mem_byte | output | 1 | 1 = byte read |
| mem_ack | input | 1 | Memory acknowledge; data valid this cycle |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the block with its default data width of 16. That choice brings the arithmetic edge cases within reach: a pre-decrement from 0 that wraps to 0xFFFF, and the byte-mode step exceptions for registers 6 and 7. The bench's memory model answers after a wait of two cycles, so every request is seen held across idle cycles. Each read returns a word computed from its address and space, so a wrong space tag or a wrong address shows up as a wrong `ea` or `operand`.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REG,
    ST_BASE,
    ST_DEC,
    ST_IDX,
    ST_SUM,
    ST_PTR,
    ST_OPER,
    ST_DONE
  } state_t;

  localparam logic [2:0] PC_IDX = 3'd7;
  localparam logic [2:0] SP_IDX = 3'd6;

  // Byte-sized step only for general registers below the stack pointer
  function automatic logic small_step(input logic byte_m, input logic [2:0] r);
    small_step = byte_m && (r < SP_IDX);
  endfunction

  // Mode uses the register directly as an address (space follows register)
  function automatic logic direct_mode(input logic [2:0] m);
    direct_mode = (m == 3'd1) || (m == 3'd2) || (m == 3'd4);
  endfunction

endpackage

// File: rtl/amseq_ctrl.sv
module amseq_ctrl
  import amseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic [2:0] req_reg,
  input  logic       req_byte,
  input  logic       req_read,
  input  logic       mem_ack,
  output state_t     state,
  output logic [2:0] mode_q,
  output logic [2:0] reg_q,
  output logic       byte_q,
  output logic       read_q,
  output logic       accept,
  output logic       mem_req,
  output logic       mem_dspace,
  output logic       mem_byte,
  output logic [2:0] rf_rd_idx,
  output logic       done,
  output logic       idle
);

  state_t nxt;
  logic   after_addr;   // state that follows once the address is known

  assign accept     = (state == ST_IDLE) && req_valid;
  assign after_addr = read_q ? 1'b1 : 1'b0;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        unique case (req_mode)
          3'd0:                nxt = ST_REG;
          3'd1, 3'd2, 3'd3:    nxt = ST_BASE;
          3'd4, 3'd5:          nxt = ST_DEC;
          default:             nxt = ST_IDX;
        endcase
      end
      ST_REG:  nxt = ST_DONE;
      ST_BASE: nxt = (mode_q == 3'd3) ? ST_PTR : (after_addr ? ST_OPER : ST_DONE);
      ST_DEC:  nxt = (mode_q == 3'd5) ? ST_PTR : (after_addr ? ST_OPER : ST_DONE);
      ST_IDX:  if (mem_ack) nxt = ST_SUM;
      ST_SUM:  nxt = (mode_q == 3'd7) ? ST_PTR : (after_addr ? ST_OPER : ST_DONE);
      ST_PTR:  if (mem_ack) nxt = after_addr ? ST_OPER : ST_DONE;
      ST_OPER: if (mem_ack) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= '0;
      reg_q  <= '0;
      byte_q <= 1'b0;
      read_q <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        mode_q <= req_mode;
        reg_q  <= req_reg;
        byte_q <= req_byte;
        read_q <= req_read;
      end
    end
  end

  logic reg_is_pc;
  assign reg_is_pc = (reg_q == PC_IDX);

  always_comb begin
    mem_req    = 1'b0;
    mem_dspace = 1'b0;
    mem_byte   = 1'b0;
    unique case (state)
      ST_IDX: begin
        mem_req    = 1'b1;
        mem_dspace = 1'b0;
      end
      ST_PTR: begin
        mem_req    = 1'b1;
        mem_dspace = (mode_q == 3'd7) ? 1'b1 : !reg_is_pc;
      end
      ST_OPER: begin
        mem_req    = 1'b1;
        mem_dspace = direct_mode(mode_q) ? !reg_is_pc : 1'b1;
        mem_byte   = byte_q;
      end
      default: ;
    endcase
  end

  assign rf_rd_idx = (state == ST_IDX) ? PC_IDX : reg_q;
  assign done      = (state == ST_DONE);
  assign idle      = (state == ST_IDLE);

  // R12
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !idle && !mem_req);

endmodule

// File: rtl/amseq_path.sv
module amseq_path
  import amseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  state_t        state,
  input  logic [2:0]    mode_q,
  input  logic [2:0]    reg_q,
  input  logic          byte_q,
  input  logic          accept,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic [2:0]    rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] operand,
  output logic          is_reg
);

  localparam int BW = DW / 2;
  localparam logic [DW-1:0] WORD_STEP = DW'(2);
  localparam logic [DW-1:0] BYTE_STEP = DW'(1);

  function automatic logic [DW-1:0] step_of(input logic b, input logic [2:0] r);
    step_of = small_step(b, r) ? BYTE_STEP : WORD_STEP;
  endfunction

  function automatic logic [DW-1:0] lo_part(input logic [DW-1:0] v, input logic b);
    lo_part = b ? {{(DW-BW){1'b0}}, v[BW-1:0]} : v;
  endfunction

  logic [DW-1:0] ptr_q, ea_q, opnd_q;
  logic          isreg_q;
  logic [DW-1:0] inc_amt, dec_amt, inc_val, dec_val, sum_val;

  assign inc_amt = (mode_q == 3'd3) ? WORD_STEP : step_of(byte_q, reg_q);
  assign dec_amt = (mode_q == 3'd5) ? WORD_STEP : step_of(byte_q, reg_q);
  assign inc_val = rf_rd_data + inc_amt;
  assign dec_val = rf_rd_data - dec_amt;
  assign sum_val = rf_rd_data + ptr_q;

  always_comb begin
    rf_wr_en   = 1'b0;
    rf_wr_idx  = reg_q;
    rf_wr_data = inc_val;
    unique case (state)
      ST_BASE: rf_wr_en = (mode_q == 3'd2) || (mode_q == 3'd3);
      ST_DEC: begin
        rf_wr_en   = 1'b1;
        rf_wr_data = dec_val;
      end
      ST_IDX: begin
        rf_wr_en   = mem_ack;
        rf_wr_idx  = PC_IDX;
        rf_wr_data = rf_rd_data + WORD_STEP;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_IDX:  mem_addr = rf_rd_data;
      ST_PTR:  mem_addr = ptr_q;
      ST_OPER: mem_addr = ea_q;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      ea_q    <= '0;
      opnd_q  <= '0;
      isreg_q <= 1'b0;
    end else if (accept) begin
      ea_q    <= '0;
      opnd_q  <= '0;
      isreg_q <= 1'b0;
    end else begin
      unique case (state)
        ST_REG: begin
          opnd_q  <= lo_part(rf_rd_data, byte_q);
          isreg_q <= 1'b1;
        end
        ST_BASE: if (mode_q == 3'd3) ptr_q <= rf_rd_data;
                 else                ea_q  <= rf_rd_data;
        ST_DEC:  if (mode_q == 3'd5) ptr_q <= dec_val;
                 else                ea_q  <= dec_val;
        ST_IDX:  if (mem_ack) ptr_q <= mem_rdata;
        ST_SUM:  if (mode_q == 3'd7) ptr_q <= sum_val;
                 else                ea_q  <= sum_val;
        ST_PTR:  if (mem_ack) ea_q <= mem_rdata;
        ST_OPER: if (mem_ack) opnd_q <= lo_part(mem_rdata, byte_q);
        default: ;
      endcase
    end
  end

  assign ea      = ea_q;
  assign operand = opnd_q;
  assign is_reg  = isreg_q;

endmodule

// File: rtl/amseq_top.sv
module amseq_top
  import amseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [2:0]    req_reg,
  input  logic          req_byte,
  input  logic          req_read,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] operand,
  output logic          is_reg,
  output logic [2:0]    rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic [2:0]    rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  output logic          mem_dspace,
  output logic          mem_byte,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  localparam int BW = DW / 2;

  state_t     state;
  logic [2:0] mode_q, reg_q;
  logic       byte_q, read_q, accept;

  amseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_reg    (req_reg),
    .req_byte   (req_byte),
    .req_read   (req_read),
    .mem_ack    (mem_ack),
    .state      (state),
    .mode_q     (mode_q),
    .reg_q      (reg_q),
    .byte_q     (byte_q),
    .read_q     (read_q),
    .accept     (accept),
    .mem_req    (mem_req),
    .mem_dspace (mem_dspace),
    .mem_byte   (mem_byte),
    .rf_rd_idx  (rf_rd_idx),
    .done       (done),
    .idle       (idle)
  );

  amseq_path #(.DW(DW)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .mode_q     (mode_q),
    .reg_q      (reg_q),
    .byte_q     (byte_q),
    .accept     (accept),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .rf_rd_data (rf_rd_data),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_data (rf_wr_data),
    .mem_addr   (mem_addr),
    .ea         (ea),
    .operand    (operand),
    .is_reg     (is_reg)
  );

  // Assertion support: memory activity seen since the request was taken
  logic mem_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)        mem_seen <= 1'b0;
    else if (accept)   mem_seen <= 1'b0;
    else if (mem_req)  mem_seen <= 1'b1;
  end

  // R2
  reg_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_reg |-> !mem_seen);

  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_dspace));

  // R13
  byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && byte_q |-> operand[DW-1:BW] == '0);

  // R11
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !read_q && !is_reg |-> operand == '0);

endmodule

// File: tb/test_amseq_top.sv
module test_amseq_top;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_mode = '0, req_reg = '0;
  logic          req_byte = 1'b0, req_read = 1'b0;
  logic          idle, done, is_reg;
  logic [DW-1:0] ea, operand;
  logic [2:0]    rf_rd_idx, rf_wr_idx;
  logic [DW-1:0] rf_rd_data, rf_wr_data;
  logic          rf_wr_en;
  logic          mem_req, mem_dspace, mem_byte;
  logic [DW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  amseq_top #(.DW(DW)) i_amseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_reg(req_reg), .req_byte(req_byte), .req_read(req_read),
    .idle(idle), .done(done), .ea(ea), .operand(operand), .is_reg(is_reg),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_dspace(mem_dspace), .mem_byte(mem_byte),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Register file model
  logic [DW-1:0] rf [8];
  assign rf_rd_data = rf[rf_rd_idx];
  always @(posedge clk) if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;

  // Memory model: word depends on address and space
  function automatic logic [DW-1:0] memval(input logic [DW-1:0] a, input logic ds);
    return ds ? (a ^ 16'h3C96) : (a + 16'h0F0F);
  endfunction

  int            n_reads = 0;
  int            n_byte_reads = 0;
  logic          first_ds, last_ds;
  int            wait_cnt = 0;
  logic [DW-1:0] hold_addr;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt > 0) chk("R14", "address held while waiting", mem_addr, hold_addr);
      hold_addr = mem_addr;
      if (wait_cnt == 2) begin
        wait_cnt = 0;
        mem_ack   <= 1'b1;
        mem_rdata <= memval(mem_addr, mem_dspace);
        if (n_reads == 0) first_ds = mem_dspace;
        last_ds = mem_dspace;
        n_reads++;
        if (mem_byte) n_byte_reads++;
      end else begin
        wait_cnt++;
      end
    end
  end

  // Stimulus table: mode, reg, byte, read, reg value, pc value, expected memory reads
  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  rg;
    logic        byt;
    logic        rd;
    logic [15:0] rval;
    logic [15:0] pcval;
    logic [3:0]  nreads;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd2, 1'b0, 1'b1, 16'h1234, 16'h0100, 4'd0},
    '{3'd0, 3'd3, 1'b1, 1'b1, 16'hABCD, 16'h0100, 4'd0},
    '{3'd1, 3'd1, 1'b0, 1'b1, 16'h0200, 16'h0100, 4'd1},
    '{3'd1, 3'd7, 1'b1, 1'b1, 16'h0120, 16'h0120, 4'd1},
    '{3'd2, 3'd0, 1'b1, 1'b1, 16'h0300, 16'h0100, 4'd1},
    '{3'd2, 3'd6, 1'b1, 1'b1, 16'h0400, 16'h0100, 4'd1},
    '{3'd2, 3'd7, 1'b0, 1'b1, 16'h0140, 16'h0140, 4'd1},
    '{3'd3, 3'd4, 1'b1, 1'b1, 16'h0500, 16'h0100, 4'd2},
    '{3'd3, 3'd2, 1'b0, 1'b0, 16'h0520, 16'h0100, 4'd1},
    '{3'd4, 3'd5, 1'b1, 1'b1, 16'h0000, 16'h0100, 4'd1},
    '{3'd4, 3'd6, 1'b1, 1'b1, 16'h0600, 16'h0100, 4'd1},
    '{3'd4, 3'd1, 1'b0, 1'b0, 16'h0001, 16'h0100, 4'd0},
    '{3'd5, 3'd3, 1'b0, 1'b1, 16'h0700, 16'h0100, 4'd2},
    '{3'd6, 3'd2, 1'b0, 1'b1, 16'h1000, 16'h2000, 4'd2},
    '{3'd6, 3'd7, 1'b1, 1'b1, 16'h2100, 16'h2100, 4'd2},
    '{3'd7, 3'd4, 1'b0, 1'b1, 16'h1100, 16'h2200, 4'd3},
    '{3'd7, 3'd7, 1'b0, 1'b0, 16'h2300, 16'h2300, 4'd2}
  };

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Reference model written from the requirements
  logic [DW-1:0] xr [8];
  logic [DW-1:0] x_ea, x_op;
  logic          x_isreg, x_first_ds, x_last_ds;

  task automatic ref_model(input logic [2:0] m, input logic [2:0] r, input logic b,
                           input logic rd);
    logic [DW-1:0] v, stp, s, idx;
    logic          op_ds;
    v = xr[r];
    stp = (b && r < 3'd6) ? 16'd1 : 16'd2;
    op_ds = (r != 3'd7);
    x_ea = '0; x_op = '0; x_isreg = 1'b0; x_first_ds = op_ds;
    case (m)
      3'd0: begin x_isreg = 1'b1; x_op = b ? {8'h00, v[7:0]} : v; end
      3'd1: x_ea = v;
      3'd2: begin x_ea = v; xr[r] = v + stp; end
      3'd3: begin xr[r] = v + 16'd2; x_ea = memval(v, r != 3'd7); op_ds = 1'b1; end
      3'd4: begin xr[r] = v - stp; x_ea = xr[r]; end
      3'd5: begin xr[r] = v - 16'd2; x_ea = memval(xr[r], r != 3'd7); op_ds = 1'b1; end
      default: begin
        idx = memval(xr[7], 1'b0);
        xr[7] = xr[7] + 16'd2;
        s = xr[r] + idx;
        x_first_ds = 1'b0;
        x_ea = (m == 3'd6) ? s : memval(s, 1'b1);
        op_ds = 1'b1;
      end
    endcase
    x_last_ds = op_ds;
    if (m != 3'd0 && rd) begin
      x_op = memval(x_ea, op_ds);
      if (b) x_op = {8'h00, x_op[7:0]};
    end
  endtask

  task automatic start_req(input logic [2:0] m, input logic [2:0] r, input logic b,
                           input logic rd);
    req_mode = m; req_reg = r; req_byte = b; req_read = rd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (!done && k < 60) begin
      @(negedge clk);
      k++;
    end
    chk(tag, "done reached", {15'd0, done}, 16'd1);
  endtask

  task automatic run_vec(input vec_t vv);
    string t;
    @(negedge clk);
    for (int i = 0; i < 8; i++) rf[i] = 16'h0E00 + 16'(i * 16'h11);
    rf[7] = vv.pcval;
    rf[vv.rg] = vv.rval;
    for (int i = 0; i < 8; i++) xr[i] = rf[i];
    n_reads = 0; n_byte_reads = 0;
    ref_model(vv.mode, vv.rg, vv.byt, vv.rd);
    t = mode_tag(vv.mode);
    start_req(vv.mode, vv.rg, vv.byt, vv.rd);
    wait_done(t);
    chk(t, "ea", ea, x_ea);
    chk(vv.rd ? t : "R11", "operand", operand, x_op);
    chk(t, "is_reg", {15'd0, is_reg}, {15'd0, x_isreg});
    chk(t, "register after", rf[vv.rg], xr[vv.rg]);
    chk(t, "pc after", rf[7], xr[7]);
    chk(vv.rd ? t : "R11", "memory reads", 16'(n_reads), 16'(vv.nreads));
    if (vv.mode != 3'd0 && vv.nreads > 0) begin
      chk("R10", "first space", {15'd0, first_ds}, {15'd0, x_first_ds});
      if (vv.rd) chk("R10", "operand space", {15'd0, last_ds}, {15'd0, x_last_ds});
    end
    chk("R13", "byte reads", 16'(n_byte_reads),
        (vv.byt && vv.rd && vv.mode != 3'd0) ? 16'd1 : 16'd0);
    @(negedge clk);
    chk("R12", "done drops after one cycle", {15'd0, done}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "idle in reset", {15'd0, idle}, 16'd1);
    chk("R1", "done in reset", {15'd0, done}, 16'd0);
    chk("R1", "mem_req in reset", {15'd0, mem_req}, 16'd0);
    chk("R1", "rf_wr_en in reset", {15'd0, rf_wr_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {15'd0, idle}, 16'd1);
    chk("R1", "done after reset", {15'd0, done}, 16'd0);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R12: a request while busy is ignored
    begin
      int dones;
      @(negedge clk);
      for (int i = 0; i < 8; i++) rf[i] = 16'h0800 + 16'(i);
      for (int i = 0; i < 8; i++) xr[i] = rf[i];
      n_reads = 0;
      ref_model(3'd5, 3'd3, 1'b0, 1'b1);
      start_req(3'd5, 3'd3, 1'b0, 1'b1);
      @(negedge clk);
      chk("R12", "idle low while busy", {15'd0, idle}, 16'd0);
      req_mode = 3'd0; req_reg = 3'd1; req_byte = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done("R12");
      chk("R12", "ea unaffected", ea, x_ea);
      chk("R12", "operand unaffected", operand, x_op);
      chk("R12", "is_reg unaffected", {15'd0, is_reg}, 16'd0);
      chk("R12", "register 1 untouched", rf[1], xr[1]);
      dones = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done) dones++;
      end
      chk("R12", "no extra done", 16'(dones), 16'd0);
      chk("R12", "idle again", {15'd0, idle}, 16'd1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule